// File: doc/BRIEF.md
# Convert-Start Gating and Power-Mode Controller

This block is the digital control core of a self-timed 8-bit successive-approximation converter. Time is counted in clocks. A single start input drives the whole flow. Each accepted low-to-high edge on start does two things: it wakes the converter and it fires a fixed-length internal warm-up pulse. The warm-up pulse is ORed with the start input to form a gated start. The conversion begins when the gated start falls, which is the later of the two falling edges.

During conversion the block raises busy. It then tests one bit per step, from the most significant bit down, against a digital comparator input, spending a parameterized number of clocks on each bit. When busy drops, the finished code is loaded into a result register. At that same edge the level of start chooses the power mode. If start is high the block stays awake. If start is low it powers down and waits for the next rising edge.

The result register is read through a tri-state byte port gated by active-low select and read strobes. It can be read while the block is powered down.

Top module: `sar_start_ctrl`

## Requirements
- R1: After reset, pwr_down_o is 1 and busy_o is 0. A read returns 8'h00. No conversion can start before a rising edge is accepted on start_i.
- R2: An accepted rising edge of start_i launches an internal pulse of PULSE_CYC clocks. If start_i is already low, busy_o goes high at the clock edge that comes PULSE_CYC+1 cycles after the edge that first samples start_i high.
- R3: If start_i is still high when the internal pulse ends, the conversion waits for it. busy_o goes high at the first edge that samples start_i low.
- R4: busy_o stays high for exactly DATA_W*BIT_CYC clock cycles.
- R5: Bits are tried from the MSB down, so the first trial code on trial_o is 8'h80. A bit is kept when comp_i is 1, meaning the input is at or above the trial level. With an ideal comparator the result is the input code in straight binary.
- R6: The result register changes only at the edge where busy_o falls. It holds its value otherwise, including during the next conversion.
- R7: At the edge where busy_o falls, pwr_down_o becomes the inverse of start_i. Start high keeps the block awake; start low powers it down.
- R8: An accepted rising edge clears pwr_down_o in the following cycle. A conversion is started only while pwr_down_o is 0.
- R9: A rising edge of start_i is ignored while busy_o is high or the internal pulse is running. It launches no pulse. If start_i is still high when busy_o falls, dropping start_i starts the next conversion at the next edge.
- R10: data_o carries the result only while cs_ni and rd_ni are both 0; otherwise it is high-impedance. This also works while the block is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | External convert-start level |
| comp_i | input | 1 | Comparator: 1 when input is at or above trial_o |
| cs_ni | input | 1 | Active-low chip select |
| rd_ni | input | 1 | Active-low read strobe |
| trial_o | output | DATA_W | Trial code presented to the DAC during conversion |
| busy_o | output | 1 | High while a conversion runs |
| pwr_down_o | output | 1 | High while powered down |
| data_o | output | DATA_W | Tri-state result bus |

## Verification
The comparator is modelled as an ideal compare of a bench-held input code against trial_o. Conversions are run on the codes 00 and FF (every bit rejected or kept), on A5 and 5A (alternating decisions, which expose bit-order errors), and on 80 and 7F (the MSB boundary).

Two kinds of start stimulus separate the two paths to the conversion start. A one-cycle start pulse makes the warm-up pulse set the timing. A start held past the warm-up makes its own falling edge set the timing.

A start edge raised during busy and held across the end of conversion covers three things at once. It selects the stay-awake mode. It is shown not to retrigger the warm-up, because the next conversion starts one cycle after start drops. It is followed by a run that ends with start low, which drives power-down.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sar_pwrup_pulse.sv
module sar_pwrup_pulse #(
  parameter int PULSE_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic block_i,
  output logic pulse_o,
  output logic wake_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic             start_q;
  logic [CNT_W-1:0] cnt_q;

  assign pulse_o = (cnt_q != '0);
  // rising edge accepted only when idle and no pulse in flight
  assign wake_o  = start_i & ~start_q & ~block_i & ~pulse_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_i;
      if (wake_o)       cnt_q <= CNT_W'(PULSE_CYC);
      else if (pulse_o) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  pulse_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> !$past(block_i));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              go_i,
  input  logic              wake_i,
  input  logic              comp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic              busy_o,
  output logic              pwr_down_o,
  output logic              done_o,
  output logic [DATA_W-1:0] code_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CYC_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(DATA_W - 1);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(BIT_CYC - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  bit_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_upd;
  logic              pwr_down_q;
  logic              step_end;

  assign busy_o     = (state_q == SEQ_CONV);
  assign pwr_down_o = pwr_down_q;
  assign step_end   = busy_o && (cyc_q == LAST_CYC);
  assign done_o     = step_end && (bit_q == '0);
  assign code_o     = acc_upd;

  always_comb begin
    acc_upd        = acc_q;
    acc_upd[bit_q] = comp_i;
  end

  assign trial_o = busy_o ? (acc_q | ({{(DATA_W-1){1'b0}}, 1'b1} << bit_q)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      bit_q      <= MSB_IDX;
      cyc_q      <= '0;
      acc_q      <= '0;
      pwr_down_q <= 1'b1;
    end else begin
      if (wake_i) pwr_down_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (go_i && !pwr_down_q) begin
            state_q <= SEQ_CONV;
            bit_q   <= MSB_IDX;
            cyc_q   <= '0;
            acc_q   <= '0;
          end
        end
        SEQ_CONV: begin
          if (step_end) begin
            cyc_q <= '0;
            acc_q <= acc_upd;
            if (bit_q == '0) begin
              state_q    <= SEQ_IDLE;
              pwr_down_q <= ~start_i;
            end else begin
              bit_q <= bit_q - 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R7
  mode_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (pwr_down_o == !$past(start_i)));

  // R8
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !pwr_down_o);
endmodule

// File: rtl/sar_rd_port.sv
module sar_rd_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              busy_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] result_q;
  logic              drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_q <= '0;
    else if (load_i) result_q <= code_i;
  end

  assign drive  = ~cs_ni & ~rd_ni;
  assign data_o = drive ? result_q : {DATA_W{1'bz}};

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_i) |-> $stable(result_q));
endmodule

// File: rtl/sar_start_ctrl.sv
module sar_start_ctrl #(
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 300,
  parameter int BIT_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              comp_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  output logic [DATA_W-1:0] trial_o,
  output logic              busy_o,
  output logic              pwr_down_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pulse_w, wake_w, gated_w, gated_q, go_w, done_w;
  logic [DATA_W-1:0] code_w;

  sar_pwrup_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .block_i (busy_o),
    .pulse_o (pulse_w),
    .wake_o  (wake_w)
  );

  assign gated_w = start_i | pulse_w;
  assign go_w    = gated_q & ~gated_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gated_q <= 1'b0;
    else         gated_q <= gated_w;
  end

  sar_seq #(.DATA_W(DATA_W), .BIT_CYC(BIT_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .go_i       (go_w),
    .wake_i     (wake_w),
    .comp_i     (comp_i),
    .trial_o    (trial_o),
    .busy_o     (busy_o),
    .pwr_down_o (pwr_down_o),
    .done_o     (done_w),
    .code_o     (code_w)
  );

  sar_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done_w),
    .code_i (code_w),
    .busy_i (busy_o),
    .cs_ni  (cs_ni),
    .rd_ni  (rd_ni),
    .data_o (data_o)
  );

  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!$past(gated_w) && !$past(pwr_down_o)));
endmodule

// File: tb/sar_start_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_start_ctrl_tb_top;
  localparam int DW = 8;
  localparam int PC = 300;
  localparam int BC = 4;
  localparam int CONV_CYC = DW * BC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cs_n = 1'b1;
  logic          rd_n = 1'b1;
  logic [DW-1:0] vin = '0;
  logic [DW-1:0] trial, data;
  logic          busy, pwr_down, comp;
  int            errors = 0;
  int            checks = 0;
  bit            finished = 1'b0;

  always #2.5 clk = ~clk;

  assign comp = (vin >= trial);

  sar_start_ctrl #(.DATA_W(DW), .PULSE_CYC(PC), .BIT_CYC(BC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .comp_i(comp),
    .cs_ni(cs_n), .rd_ni(rd_n), .trial_o(trial), .busy_o(busy),
    .pwr_down_o(pwr_down), .data_o(data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [DW-1:0] exp);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(req, {24'h0, data}, {24'h0, exp});
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  // run out the conversion started at the last edge; called at the negedge after busy rose
  task automatic finish_conv(input string tag, input logic [DW-1:0] exp);
    chk({tag, " R5 first trial MSB"}, {24'h0, trial}, 32'h80);
    repeat (CONV_CYC - 1) @(negedge clk);
    chk({tag, " R4 busy still high"}, {31'h0, busy}, 32'h1);
    @(negedge clk);
    chk({tag, " R4 busy low after width"}, {31'h0, busy}, 32'h0);
    read_chk({tag, " R5 result code"}, exp);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", {31'h0, busy}, 32'h0);
    chk("R1 pwr_down after reset", {31'h0, pwr_down}, 32'h1);
    read_chk("R1 result after reset", 8'h00);
  endtask

  task automatic t_short(input logic [DW-1:0] code, input logic [DW-1:0] prev);
    vin = code;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8 wake clears pwr_down", {31'h0, pwr_down}, 32'h0);
    repeat (PC) @(negedge clk);
    chk("R2 busy low during pulse", {31'h0, busy}, 32'h0);
    read_chk("R6 result held before conversion", prev);
    @(negedge clk);
    chk("R2 busy rises after pulse", {31'h0, busy}, 32'h1);
    finish_conv("short", code);
    chk("R7 start low -> power down", {31'h0, pwr_down}, 32'h1);
  endtask

  task automatic t_long_mode1(input logic [DW-1:0] c1, input logic [DW-1:0] c2,
                              input logic [DW-1:0] prev);
    vin = c1;
    @(negedge clk) start = 1'b1;
    repeat (PC + 20) @(negedge clk);
    chk("R3 waits for external fall", {31'h0, busy}, 32'h0);
    start = 1'b0;
    @(negedge clk);
    chk("R3 busy on external fall", {31'h0, busy}, 32'h1);
    repeat (10) @(negedge clk);
    start = 1'b1;  // rise while busy: must be ignored
    read_chk("R6 old result during conversion", prev);
    repeat (CONV_CYC - 11) @(negedge clk);
    chk("R4 busy still high (long)", {31'h0, busy}, 32'h1);
    @(negedge clk);
    chk("R4 busy low (long)", {31'h0, busy}, 32'h0);
    chk("R7 start high -> stay awake", {31'h0, pwr_down}, 32'h0);
    read_chk("R5 result long", c1);
    vin = c2;
    start = 1'b0;
    @(negedge clk);
    chk("R9 no retrigger, immediate start", {31'h0, busy}, 32'h1);
    finish_conv("mode1", c2);
    chk("R7 start low at end -> power down", {31'h0, pwr_down}, 32'h1);
  endtask

  task automatic t_port(input logic [DW-1:0] exp);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk("R10 hi-z with cs high", {24'h0, data}, {24'h0, 8'hzz});
    cs_n = 1'b0; rd_n = 1'b1; #1;
    chk("R10 hi-z with rd high", {24'h0, data}, {24'h0, 8'hzz});
    cs_n = 1'b1;
    chk("R10 powered down during read", {31'h0, pwr_down}, 32'h1);
    read_chk("R10 read while powered down", exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short(8'hA5, 8'h00);
    t_short(8'h00, 8'hA5);
    t_short(8'hFF, 8'h00);
    t_long_mode1(8'h5A, 8'h80, 8'hFF);
    t_short(8'h7F, 8'h80);
    t_port(8'h7F);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule